// File: doc/BRIEF.md
# Multiplexed-Bus Master with Read Voting and Write Verify

This block is a synchronous master that reads and writes single registers in a small external logic device over a narrow shared address/data bus. Three control lines run alongside the bus: an active-low select, a direction line and a phase line. A caller presents one command at a time, with a direction flag, a 5-bit register address and 5-bit write data. When the command completes, the block returns the read value with a one-cycle completion pulse.

The external link is not trusted to be clean. A read is therefore repeated, and each new sample is compared with the samples already taken. The read ends once a sample matches enough earlier ones, or once the attempt limit is reached. A write aimed at a state-setting register (address bit 3 or bit 4 set) is checked by a voted read of the matching status register. That status address is formed by clearing bits 4:3 and then setting bit 4. If the readback differs from the written data, the write is repeated, up to the attempt limit.

The bus pins are modelled as separate output, output-enable and input vectors.

FSM states:
- `ST_IDLE`: everything parked high.
- `ST_ADDR`: address driven, select still high.
- `ST_SEL`: select low, address held for the setup interval.
- `ST_DATA`: phase line high, the bus released or driven with data, for a second setup interval.
- `ST_REL`: one parked cycle after every access.

Transitions:
- IDLE→ADDR when a command is accepted.
- ADDR→SEL always.
- SEL→DATA when the setup timer expires.
- DATA→REL when the setup timer expires. The sample is taken and the next action is decided on this transition.
- REL→ADDR when another access follows.
- REL→IDLE when the command is finished, raising the done pulse.

Top module: `mbm_master`

## Requirements
- R1: During and after reset, and whenever the block is idle, `cs_n`, `rw` and `ad` are 1, `bus_out` is all ones, `bus_oe` is all ones, and `busy` and `done` are 0.
- R2: A read access behaves as follows. `rw`=1 throughout. The address is driven with `ad`=0 for one cycle before `cs_n` falls. `cs_n` stays low for 2×SETUP_CYC cycles. For the second half of that time `ad`=1 and `bus_oe`=0, and the value sampled on `bus_in` in the last cycle is the result of the attempt.
- R3: A write access follows the same timing with `rw`=0. In the data phase (`ad`=1) the bus is driven (`bus_oe` all ones) with the write data.
- R4: After every access, `cs_n` returns high with all pins parked for at least one cycle before the next access.
- R5: A read stops at the first attempt whose sample equals at least VOTE_NEED (default 2) earlier samples of the same command, and it returns that sample.
- R6: A read makes at most MAX_TRY (default 5) attempts. If no attempt reaches the vote, it returns the last sample.
- R7: A write is verified only when address bit 4 or bit 3 is 1. The verify read targets {1'b1, 1'b0, addr[2:0]}. A write without verify makes exactly one write access and no read access, and reports `rdata`=0.
- R8: A verified write uses a voted read (R5, R6) for its readback. If the voted value differs from the write data, the write is repeated with a fresh voted readback, up to MAX_TRY writes. `rdata` reports the last readback.
- R9: `verify_fail` is 1 from the done pulse until the next accepted command when all MAX_TRY write attempts failed verification. Otherwise it is 0.
- R10: A command is accepted only when `cmd_valid`=1 and `busy`=0. `busy` is 1 from the cycle after acceptance until completion. `done` is a single-cycle pulse in the first idle cycle. `cmd_valid` while busy has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command request, taken when not busy |
| cmd_write | input | 1 | 1 = write command, 0 = read command |
| cmd_addr | input | 5 | Device register address |
| cmd_wdata | input | 5 | Write data |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| verify_fail | output | 1 | Last write exhausted its attempts without a matching readback |
| rdata | output | 5 | Read result, or last verify readback |
| bus_out | output | 5 | Bus output values |
| bus_oe | output | 5 | Bus output enables, 1 = driven |
| bus_in | input | 5 | Bus input values |
| cs_n | output | 1 | Device select, active low |
| rw | output | 1 | Direction line, 1 = read, 0 = write |
| ad | output | 1 | Phase line, 0 = address, 1 = data |

## Verification
The bench builds the block with its defaults: SETUP_CYC=4, MAX_TRY=5 and VOTE_NEED=2. At the 50 MHz bench clock, SETUP_CYC=4 covers a setup interval of at least 70 ns, and each access takes ten cycles. With these values a five-attempt read with no majority, a write repaired on its second attempt, and a write that exhausts all five attempts (fifteen verify reads) each finish within a few hundred cycles. A device model in the bench serves stored values or scripted per-attempt sequences, and it can corrupt a set number of status updates. This is what drives the voting and retry paths.

// File: rtl/mbm_pkg.sv
package mbm_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_SEL,
        ST_DATA,
        ST_REL
    } mbm_state_e;
endpackage

// File: rtl/mbm_phase_timer.sv
// Counts the cycles of one bus phase; last is high in its final cycle.
module mbm_phase_timer #(
    parameter int SETUP_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic last
);
    localparam int CW = (SETUP_CYC > 1) ? $clog2(SETUP_CYC) : 1;

    logic [CW-1:0] cnt_q;

    assign last = run && (cnt_q == CW'(SETUP_CYC - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              cnt_q <= '0;
        else if (!run || last)   cnt_q <= '0;
        else                     cnt_q <= cnt_q + 1'b1;
    end

    // R2
    phase_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run && !last |=> run);
endmodule

// File: rtl/mbm_vote.sv
// Holds the samples of one voted read and counts matches with a new sample.
module mbm_vote #(
    parameter int BUS_W   = 5,
    parameter int MAX_TRY = 5
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           clear,
    input  logic                           push,
    input  logic [BUS_W-1:0]               sample,
    output logic [$clog2(MAX_TRY+1)-1:0]   agree
);
    localparam int CW = $clog2(MAX_TRY + 1);
    localparam int IW = (MAX_TRY > 1) ? $clog2(MAX_TRY) : 1;

    logic [BUS_W-1:0]   hist_q [MAX_TRY];
    logic [MAX_TRY-1:0] vld_q;
    logic [MAX_TRY-1:0] hit;
    logic [IW-1:0]      wr_idx_q;

    for (genvar g = 0; g < MAX_TRY; g++) begin : g_cmp
        assign hit[g] = vld_q[g] && (hist_q[g] == sample);
    end

    assign agree = CW'($countones(hit));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vld_q    <= '0;
            wr_idx_q <= '0;
        end else if (clear) begin
            vld_q    <= '0;
            wr_idx_q <= '0;
        end else if (push) begin
            vld_q[wr_idx_q] <= 1'b1;
            wr_idx_q        <= wr_idx_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (push && !clear) hist_q[wr_idx_q] <= sample;
    end

    // R6
    hist_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push && !clear |-> wr_idx_q < IW'(MAX_TRY));
endmodule

// File: rtl/mbm_pin_drive.sv
// Decodes FSM state and access kind into pin levels.
module mbm_pin_drive
    import mbm_pkg::*;
#(
    parameter int BUS_W = 5
) (
    input  mbm_state_e       state,
    input  logic             acc_wr,
    input  logic [BUS_W-1:0] addr,
    input  logic [BUS_W-1:0] wdata,
    output logic [BUS_W-1:0] bus_out,
    output logic [BUS_W-1:0] bus_oe,
    output logic             cs_n,
    output logic             rw,
    output logic             ad
);
    always_comb begin
        bus_out = '1;
        bus_oe  = '1;
        cs_n    = 1'b1;
        rw      = 1'b1;
        ad      = 1'b1;
        unique case (state)
            ST_IDLE, ST_REL: ;
            ST_ADDR: begin
                rw      = !acc_wr;
                ad      = 1'b0;
                bus_out = addr;
            end
            ST_SEL: begin
                cs_n    = 1'b0;
                rw      = !acc_wr;
                ad      = 1'b0;
                bus_out = addr;
            end
            ST_DATA: begin
                cs_n    = 1'b0;
                rw      = !acc_wr;
                bus_out = acc_wr ? wdata : '1;
                bus_oe  = acc_wr ? '1 : '0;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/mbm_master.sv
module mbm_master
    import mbm_pkg::*;
#(
    parameter int BUS_W     = 5,
    parameter int SETUP_CYC = 4,
    parameter int MAX_TRY   = 5,
    parameter int VOTE_NEED = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic             cmd_write,
    input  logic [BUS_W-1:0] cmd_addr,
    input  logic [BUS_W-1:0] cmd_wdata,
    output logic             busy,
    output logic             done,
    output logic             verify_fail,
    output logic [BUS_W-1:0] rdata,
    output logic [BUS_W-1:0] bus_out,
    output logic [BUS_W-1:0] bus_oe,
    input  logic [BUS_W-1:0] bus_in,
    output logic             cs_n,
    output logic             rw,
    output logic             ad
);
    localparam int CW = $clog2(MAX_TRY + 1);
    localparam int TW = $clog2(MAX_TRY + 1);

    mbm_state_e       state_q, state_d;
    logic             acc_wr_q, op_wr_q, fin_q, fail_q, done_q;
    logic [BUS_W-1:0] cmd_addr_q, wdata_q, acc_addr_q, rdata_q;
    logic [TW-1:0]    rtry_q, wtry_q;
    logic             tmr_last, accept, data_end, need_vfy, rd_stop;
    logic             vote_clear, vote_push;
    logic [CW-1:0]    agree;
    logic [BUS_W-1:0] vfy_addr;

    assign accept   = (state_q == ST_IDLE) && cmd_valid;
    assign data_end = (state_q == ST_DATA) && tmr_last;
    // set-state addresses (bit 4 or 3) map to get-state: clear both, set bit 4
    assign need_vfy = |cmd_addr_q[BUS_W-1:BUS_W-2];
    assign vfy_addr = {2'b10, cmd_addr_q[BUS_W-3:0]};
    assign rd_stop  = (agree >= CW'(VOTE_NEED)) || (rtry_q == TW'(MAX_TRY - 1));

    assign vote_clear = accept || (data_end && acc_wr_q);
    assign vote_push  = data_end && !acc_wr_q;

    mbm_phase_timer #(.SETUP_CYC(SETUP_CYC)) u_tmr (
        .clk  (clk),
        .rst_n(rst_n),
        .run  ((state_q == ST_SEL) || (state_q == ST_DATA)),
        .last (tmr_last)
    );

    mbm_vote #(.BUS_W(BUS_W), .MAX_TRY(MAX_TRY)) u_vote (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (vote_clear),
        .push  (vote_push),
        .sample(bus_in),
        .agree (agree)
    );

    mbm_pin_drive #(.BUS_W(BUS_W)) u_pins (
        .state  (state_q),
        .acc_wr (acc_wr_q),
        .addr   (acc_addr_q),
        .wdata  (wdata_q),
        .bus_out(bus_out),
        .bus_oe (bus_oe),
        .cs_n   (cs_n),
        .rw     (rw),
        .ad     (ad)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (cmd_valid) state_d = ST_ADDR;
            ST_ADDR: state_d = ST_SEL;
            ST_SEL:  if (tmr_last) state_d = ST_DATA;
            ST_DATA: if (tmr_last) state_d = ST_REL;
            ST_REL:  state_d = fin_q ? ST_IDLE : ST_ADDR;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_wr_q   <= 1'b0;
            op_wr_q    <= 1'b0;
            fin_q      <= 1'b0;
            fail_q     <= 1'b0;
            done_q     <= 1'b0;
            cmd_addr_q <= '0;
            wdata_q    <= '0;
            acc_addr_q <= '0;
            rdata_q    <= '0;
            rtry_q     <= '0;
            wtry_q     <= '0;
        end else begin
            done_q <= (state_q == ST_REL) && fin_q;
            if (accept) begin
                op_wr_q    <= cmd_write;
                acc_wr_q   <= cmd_write;
                cmd_addr_q <= cmd_addr;
                acc_addr_q <= cmd_addr;
                wdata_q    <= cmd_wdata;
                rtry_q     <= '0;
                wtry_q     <= '0;
                fin_q      <= 1'b0;
                fail_q     <= 1'b0;
                if (cmd_write) rdata_q <= '0;
            end else if (data_end && acc_wr_q) begin
                if (need_vfy) begin
                    acc_wr_q   <= 1'b0;
                    acc_addr_q <= vfy_addr;
                    rtry_q     <= '0;
                end else begin
                    fin_q <= 1'b1;
                end
            end else if (data_end) begin
                if (!rd_stop) begin
                    rtry_q <= rtry_q + 1'b1;
                end else begin
                    rdata_q <= bus_in;
                    if (!op_wr_q || bus_in == wdata_q) begin
                        fin_q <= 1'b1;
                    end else if (wtry_q == TW'(MAX_TRY - 1)) begin
                        fin_q  <= 1'b1;
                        fail_q <= 1'b1;
                    end else begin
                        wtry_q     <= wtry_q + 1'b1;
                        acc_wr_q   <= 1'b1;
                        acc_addr_q <= cmd_addr_q;
                    end
                end
            end
        end
    end

    assign busy        = (state_q != ST_IDLE);
    assign done        = done_q;
    assign verify_fail = fail_q && !busy;
    assign rdata       = rdata_q;

    // R2
    addr_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_n) |-> !ad && $stable(bus_out));
    // R3
    rw_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_n |-> $stable(rw));
    // R4
    idle_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_n) |=> cs_n);
    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R10
    busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);
    // R9
    fail_at_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(verify_fail) |-> done);
    // R8
    wtry_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> wtry_q < TW'(MAX_TRY));
endmodule

// File: tb/sim_mbm_master.sv
module sim_mbm_master;
    localparam int BW    = 5;
    localparam int SETUP = 4;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic          rst_n, cmd_valid, cmd_write;
    logic [BW-1:0] cmd_addr, cmd_wdata;
    logic          busy, done, verify_fail;
    logic [BW-1:0] rdata, bus_out, bus_oe, bus_in;
    logic          cs_n, rw, ad;

    int checks = 0;
    int fails  = 0;

    mbm_master u0 (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_write(cmd_write),
        .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .busy(busy), .done(done),
        .verify_fail(verify_fail), .rdata(rdata), .bus_out(bus_out), .bus_oe(bus_oe),
        .bus_in(bus_in), .cs_n(cs_n), .rw(rw), .ad(ad)
    );

    // external device model
    logic [4:0] mem [32];
    logic [4:0] force_seq [5];
    logic [4:0] dev_addr = '0, dev_wdata = '0, last_rd_addr = '0, rd_val;
    logic       dev_rw = 1'b1, cs_prev = 1'b1;
    bit         force_on = 0, oe_bad = 0;
    int         n_rd = 0, n_wr = 0, rd_idx = 0, corrupt_cnt = 0;
    int         cs_len = 0, last_cs_len = 0;

    always_comb rd_val = force_on ? force_seq[(rd_idx < 5) ? rd_idx : 4] : mem[dev_addr];
    assign bus_in = (!cs_n && ad && dev_rw) ? rd_val : 5'h1F;

    always @(posedge clk) begin
        if (!cs_n && !ad) begin
            dev_addr = bus_out;
            dev_rw   = rw;
            if (bus_oe != 5'h1F) oe_bad = 1;
        end
        if (!cs_n && ad) begin
            if (!dev_rw) dev_wdata = bus_out;
            if (rw && bus_oe != 5'h00) oe_bad = 1;
            if (!rw && bus_oe != 5'h1F) oe_bad = 1;
        end
        if (!cs_n) cs_len++;
        if (cs_n && !cs_prev) begin
            last_cs_len = cs_len;
            cs_len = 0;
            if (!dev_rw) begin
                mem[dev_addr] = dev_wdata;
                if (dev_addr[4:3] != 2'b00) begin
                    mem[{2'b10, dev_addr[2:0]}] = (corrupt_cnt > 0) ? (dev_wdata ^ 5'h01) : dev_wdata;
                    if (corrupt_cnt > 0) corrupt_cnt--;
                end
                n_wr++;
            end else begin
                last_rd_addr = dev_addr;
                n_rd++;
                rd_idx++;
            end
        end
        cs_prev = cs_n;
    end

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    task automatic idle_pins(input string req);
        chk(cs_n == 1 && rw == 1 && ad == 1, req, "control pins idle", {cs_n, rw, ad}, 3'b111);
        chk(bus_out == 5'h1F && bus_oe == 5'h1F, req, "bus parked", {bus_out, bus_oe}, 10'h3FF);
    endtask

    task automatic run_cmd(input bit w, input logic [4:0] a, input logic [4:0] d,
                           output logic [4:0] rd, output bit vf);
        int cyc;
        n_rd = 0; n_wr = 0; rd_idx = 0;
        @(negedge clk);
        cmd_valid = 1; cmd_write = w; cmd_addr = a; cmd_wdata = d;
        @(negedge clk);
        cmd_valid = 0;
        chk(busy == 1, "R10", "busy after accept", busy, 1);
        cyc = 0;
        while (!done && cyc < 3000) begin
            @(negedge clk);
            cyc++;
        end
        chk(done == 1, "R10", "done seen before timeout", done, 1);
        rd = rdata;
        vf = verify_fail;
        @(negedge clk);
        chk(done == 0, "R10", "done lasts one cycle", done, 0);
    endtask

    // {wr, addr, wdata, exp_rdata, exp_reads, exp_writes}
    localparam logic [23:0] VEC [8] = '{
        {1'b1, 5'h03, 5'h15, 5'h00, 4'd0, 4'd1},
        {1'b0, 5'h03, 5'h00, 5'h15, 4'd3, 4'd0},
        {1'b1, 5'h1A, 5'h0C, 5'h0C, 4'd3, 4'd1},
        {1'b0, 5'h12, 5'h00, 5'h0C, 4'd3, 4'd0},
        {1'b1, 5'h0D, 5'h07, 5'h07, 4'd3, 4'd1},
        {1'b0, 5'h15, 5'h00, 5'h07, 4'd3, 4'd0},
        {1'b1, 5'h1F, 5'h1F, 5'h1F, 4'd3, 4'd1},
        {1'b0, 5'h00, 5'h00, 5'h00, 4'd3, 4'd0}
    };

    initial begin
        #(20 * 200000);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [4:0] rd;
        bit vf;
        for (int i = 0; i < 32; i++) mem[i] = '0;
        rst_n = 0; cmd_valid = 0; cmd_write = 0; cmd_addr = '0; cmd_wdata = '0;
        repeat (3) @(negedge clk);
        // R1 reset state
        idle_pins("R1");
        chk(busy == 0 && done == 0, "R1", "busy/done in reset", {busy, done}, 0);
        rst_n = 1;
        @(negedge clk);
        idle_pins("R1");

        // vector table
        for (int v = 0; v < 8; v++) begin
            run_cmd(VEC[v][23], VEC[v][22:18], VEC[v][17:13], rd, vf);
            chk(rd == VEC[v][12:8], "R5", $sformatf("vec%0d rdata", v), rd, VEC[v][12:8]);
            chk(n_rd == int'(VEC[v][7:4]), "R7", $sformatf("vec%0d read accesses", v), n_rd, VEC[v][7:4]);
            chk(n_wr == int'(VEC[v][3:0]), "R7", $sformatf("vec%0d write accesses", v), n_wr, VEC[v][3:0]);
            chk(vf == 0, "R9", $sformatf("vec%0d no verify fail", v), vf, 0);
            if (VEC[v][23] && VEC[v][22:21] != 2'b00)
                chk(last_rd_addr == {2'b10, VEC[v][20:18]}, "R7", "verify address",
                    last_rd_addr, {2'b10, VEC[v][20:18]});
            idle_pins("R4");
        end
        chk(last_cs_len == 2 * SETUP, "R2", "select low length", last_cs_len, 2 * SETUP);
        chk(oe_bad == 0, "R3", "bus enable per phase", oe_bad, 0);

        // R5: vote reached on fourth attempt
        force_on = 1;
        force_seq[0] = 5'h0A; force_seq[1] = 5'h11; force_seq[2] = 5'h0A;
        force_seq[3] = 5'h0A; force_seq[4] = 5'h02;
        run_cmd(0, 5'h06, 5'h00, rd, vf);
        chk(rd == 5'h0A, "R5", "vote value", rd, 5'h0A);
        chk(n_rd == 4, "R5", "vote attempts", n_rd, 4);

        // R6: no majority, last sample returned
        force_seq[0] = 5'h01; force_seq[1] = 5'h02; force_seq[2] = 5'h01;
        force_seq[3] = 5'h02; force_seq[4] = 5'h03;
        run_cmd(0, 5'h06, 5'h00, rd, vf);
        chk(rd == 5'h03, "R6", "exhausted read value", rd, 5'h03);
        chk(n_rd == 5, "R6", "exhausted read attempts", n_rd, 5);
        force_seq[0] = 5'h04; force_seq[1] = 5'h05; force_seq[2] = 5'h06;
        force_seq[3] = 5'h07; force_seq[4] = 5'h08;
        run_cmd(0, 5'h06, 5'h00, rd, vf);
        chk(rd == 5'h08 && n_rd == 5, "R6", "all distinct", {rd, 8'(n_rd)}, {5'h08, 8'd5});
        force_on = 0;

        // R8: one corrupted readback, repaired on second write
        corrupt_cnt = 1;
        run_cmd(1, 5'h19, 5'h06, rd, vf);
        chk(n_wr == 2, "R8", "write attempts after one bad verify", n_wr, 2);
        chk(n_rd == 6, "R8", "verify reads", n_rd, 6);
        chk(rd == 5'h06 && vf == 0, "R8", "final readback", {vf, rd}, 6'h06);

        // R9: every verify fails
        corrupt_cnt = 100;
        run_cmd(1, 5'h18, 5'h1E, rd, vf);
        chk(n_wr == 5, "R9", "write attempts exhausted", n_wr, 5);
        chk(n_rd == 15, "R9", "verify reads exhausted", n_rd, 15);
        chk(vf == 1, "R9", "fail flag", vf, 1);
        chk(rd == 5'h1F, "R9", "last readback", rd, 5'h1F);
        corrupt_cnt = 0;
        run_cmd(0, 5'h02, 5'h00, rd, vf);
        chk(vf == 0, "R9", "fail flag cleared by next command", vf, 0);

        // R10: commands while busy are ignored
        n_rd = 0; n_wr = 0; rd_idx = 0;
        @(negedge clk);
        cmd_valid = 1; cmd_write = 1; cmd_addr = 5'h04; cmd_wdata = 5'h09;
        @(negedge clk);
        cmd_addr = 5'h05; cmd_wdata = 5'h1B;
        repeat (5) @(negedge clk);
        cmd_valid = 0;
        while (!done) @(negedge clk);
        @(negedge clk);
        chk(n_wr == 1 && n_rd == 0, "R10", "single access for ignored request", n_wr, 1);
        run_cmd(0, 5'h05, 5'h00, rd, vf);
        chk(rd == 5'h00, "R10", "ignored write left register", rd, 5'h00);
        run_cmd(0, 5'h04, 5'h00, rd, vf);
        chk(rd == 5'h09, "R10", "accepted write landed", rd, 5'h09);
        chk(oe_bad == 0, "R2", "bus enable per phase at end", oe_bad, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule